// File: doc/BRIEF.md
# Two-Level Audio Error Interrupt Controller

This block gathers single-cycle event pulses from five audio error and status sources and turns them into one interrupt line. Each source is a bank of per-port status bits. Banks 0, 1 and 3 serve the playback side: FIFO underflow, ring-buffer underflow and free-mark reached. Banks 2 and 4 serve the capture side: ring-buffer overflow and full-mark reached. A status bit records its event whether or not that port is masked. The mask only decides whether the bank passes the event upward.

The upper level holds one latched bit per bank. A bank sets its bit whenever it has any unmasked pending port. That level has its own mask, and the interrupt output is the OR of its unmasked bits. A read-only group word tells software whether the playback class, the capture class, or both need service.

All masks change only through separate write-1 set and write-1 clear locations. All status bits are cleared through write-1 clear locations. Software reaches every register through a single-cycle register port.

Top module: `aud_err_irq_ctrl`

## Requirements
- R1: After reset every bank status and the summary status read 0. Every mask reads all ones over its port width, with the summary mask at 0x1F. `irq_o` is low.
- R2: A pulse on `evt_i[4*b+p]` sets bit p of bank b at the next edge, even while that port is masked. A masked port raises neither the summary bit nor `irq_o`.
- R3: Writing to a bank's clear location (address 8*b+1) clears the status bits written as 1. Bits written as 0 keep their value.
- R4: Writing to mask set (8*b+3) sets the mask bits written as 1, and writing to mask clear (8*b+4) clears them. Zeros have no effect, and the mask reads back at 8*b+2.
- R5: Summary bit b (read at 0x28) latches one edge after bank b holds any status bit with its mask bit clear. It therefore first reads as 1 on a read issued one cycle after the bank bit sets.
- R6: Writing 1s to the summary clear location (0x29) clears those summary bits, unless the bank still has an unmasked pending bit. In that case the bit stays set.
- R7: `irq_o` is high exactly when some summary bit is set and its summary mask bit is clear. The summary mask is set and cleared at 0x2B and 0x2C, and it reads back at 0x2A.
- R8: Capture banks (2 and 4) have 3 ports. Event bit 3 of those banks is ignored, and status and mask bit 3 of those banks always read 0.
- R9: The group word at 0x2D holds the playback class in bit 0 (unmasked summary bits 0, 1 or 3) and the capture class in bit 1 (unmasked summary bits 2 or 4).
- R10: A read strobe returns data one edge later. Write-only locations (offsets 1, 3 and 4), unused offsets and addresses at or above 0x30 read as 0.
- R11: When an event and a status clear hit the same bit in the same cycle, the event wins and the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | NUM_BANKS*PLAY_PORTS (20) | Event pulses, bit 4*b+p for bank b, port p |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W (6) | Register address: bank in bits 5:3, offset in bits 2:0 |
| reg_wdata | input | DATA_W (8) | Write data |
| reg_rdata | output | DATA_W (8) | Read data, valid one edge after the read strobe |
| irq_o | output | 1 | Combined interrupt |

## Verification
A bank status bit is due one edge after its event. The summary bit is due one edge later still. `irq_o` follows the summary bit and summary mask with no further register, and read data lands one edge after its strobe. The bench drives every stimulus on a falling edge and samples on the next falling edge after the counted rising edges. It reads the summary status right after an event and expects 0 there, then expects 1 on the following read, which pins the two-stage latency. The interrupt line is checked on the falling edge that follows the mask write.

// File: rtl/aud_err_irq_pkg.sv
package aud_err_irq_pkg;

    localparam int NUM_BANKS = 5;
    localparam int OFS_W     = 3;

    // Bank index doubles as the region field of the register address.
    typedef enum logic [2:0] {
        BANK_FIFO_UNDER = 3'd0,
        BANK_RING_UNDER = 3'd1,
        BANK_RING_OVER  = 3'd2,
        BANK_FREE_MARK  = 3'd3,
        BANK_FULL_MARK  = 3'd4,
        REGION_SUMMARY  = 3'd5
    } region_e;

    typedef enum logic [OFS_W-1:0] {
        OFS_STATUS   = 3'd0,
        OFS_CLEAR    = 3'd1,
        OFS_MASK     = 3'd2,
        OFS_MASK_SET = 3'd3,
        OFS_MASK_CLR = 3'd4,
        OFS_GROUP    = 3'd5
    } offset_e;

    localparam logic [NUM_BANKS-1:0] PLAY_GROUP = 5'b01011;
    localparam logic [NUM_BANKS-1:0] CAPT_GROUP = 5'b10100;

    typedef struct packed {
        logic clr;
        logic mset;
        logic mclr;
    } wr_strobe_t;

    function automatic bit bank_is_playback(input int b);
        return PLAY_GROUP[b];
    endfunction

endpackage

// File: rtl/aud_err_bank.sv
module aud_err_bank
    import aud_err_irq_pkg::*;
#(
    parameter int PORTS = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PORTS-1:0] evt,
    input  wr_strobe_t       wr,
    input  logic [PORTS-1:0] wbits,
    output logic [PORTS-1:0] status,
    output logic [PORTS-1:0] mask,
    output logic             pend
);

    logic [PORTS-1:0] clr_bits;
    logic [PORTS-1:0] set_bits;
    logic [PORTS-1:0] unm_bits;

    assign clr_bits = wr.clr  ? wbits : '0;
    assign set_bits = wr.mset ? wbits : '0;
    assign unm_bits = wr.mclr ? wbits : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
            mask   <= '1;
        end else begin
            // event applied after the clear: an event in the same cycle wins
            status <= (status & ~clr_bits) | evt;
            mask   <= (mask | set_bits) & ~unm_bits;
        end
    end

    assign pend = |(status & ~mask);

    // R2, R11: an event is recorded regardless of mask or concurrent clear
    p_evt_latch_r2: assert property (@(posedge clk) disable iff (rst)
        (evt != '0) |=> ((status & $past(evt)) == $past(evt)));

    // R3: written ones clear status unless an event lands on the same bit
    p_clear_r3: assert property (@(posedge clk) disable iff (rst)
        wr.clr |=> ((status & $past(wbits & ~evt)) == '0));

    // R4: mask set writes take effect on the next edge
    p_mask_set_r4: assert property (@(posedge clk) disable iff (rst)
        wr.mset |=> ((mask & $past(wbits)) == $past(wbits)));

    // R4: mask clear writes take effect on the next edge
    p_mask_clr_r4: assert property (@(posedge clk) disable iff (rst)
        wr.mclr |=> ((mask & $past(wbits)) == '0));

endmodule

// File: rtl/aud_err_summary.sv
module aud_err_summary
    import aud_err_irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_BANKS-1:0] bank_pend,
    input  wr_strobe_t           wr,
    input  logic [NUM_BANKS-1:0] wbits,
    output logic [NUM_BANKS-1:0] top_status,
    output logic [NUM_BANKS-1:0] top_mask,
    output logic [1:0]           group,
    output logic                 irq
);

    logic [NUM_BANKS-1:0] clr_bits;
    logic [NUM_BANKS-1:0] set_bits;
    logic [NUM_BANKS-1:0] unm_bits;
    logic [NUM_BANKS-1:0] active;

    assign clr_bits = wr.clr  ? wbits : '0;
    assign set_bits = wr.mset ? wbits : '0;
    assign unm_bits = wr.mclr ? wbits : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            top_status <= '0;
            top_mask   <= '1;
        end else begin
            top_status <= (top_status & ~clr_bits) | bank_pend;
            top_mask   <= (top_mask | set_bits) & ~unm_bits;
        end
    end

    assign active   = top_status & ~top_mask;
    assign group[0] = |(active & PLAY_GROUP);
    assign group[1] = |(active & CAPT_GROUP);
    assign irq      = |active;

    // R5, R6: a pending bank sets (or keeps) its summary bit at the next edge
    p_top_latch_r5: assert property (@(posedge clk) disable iff (rst)
        (bank_pend != '0) |=> ((top_status & $past(bank_pend)) == $past(bank_pend)));

    // R7: a fully masked summary level never interrupts
    p_irq_masked_r7: assert property (@(posedge clk) disable iff (rst)
        (&top_mask) |-> !irq);

    // R9: any class flag implies the interrupt line
    p_group_irq_r9: assert property (@(posedge clk) disable iff (rst)
        (group != 2'b00) |-> irq);

endmodule

// File: rtl/aud_err_irq_ctrl.sv
module aud_err_irq_ctrl
    import aud_err_irq_pkg::*;
#(
    parameter int PLAY_PORTS = 4,
    parameter int CAPT_PORTS = 3,
    parameter int DATA_W     = 8,
    parameter int ADDR_W     = 6
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [NUM_BANKS*PLAY_PORTS-1:0] evt_i,
    input  logic                            reg_wr_en,
    input  logic                            reg_rd_en,
    input  logic [ADDR_W-1:0]               reg_addr,
    input  logic [DATA_W-1:0]               reg_wdata,
    output logic [DATA_W-1:0]               reg_rdata,
    output logic                            irq_o
);

    localparam int REGION_W = ADDR_W - OFS_W;
    localparam int SUMMARY  = NUM_BANKS;

    logic [REGION_W-1:0]   region;
    logic [OFS_W-1:0]      ofs;
    wr_strobe_t            wr_sel [SUMMARY+1];

    logic [PLAY_PORTS-1:0] bank_status [NUM_BANKS];
    logic [PLAY_PORTS-1:0] bank_mask   [NUM_BANKS];
    logic [NUM_BANKS-1:0]  bank_pend;

    logic [NUM_BANKS-1:0]  top_status;
    logic [NUM_BANKS-1:0]  top_mask;
    logic [1:0]            group;
    logic [DATA_W-1:0]     rd_next;
    logic                  unused_wdata;

    assign region       = reg_addr[ADDR_W-1:OFS_W];
    assign ofs          = reg_addr[OFS_W-1:0];
    assign unused_wdata = ^reg_wdata;

    // write strobe decode, one set per region (banks then summary)
    for (genvar r = 0; r <= SUMMARY; r++) begin : g_dec
        logic hit;
        assign hit          = reg_wr_en && (region == REGION_W'(r));
        assign wr_sel[r].clr  = hit && (ofs == OFS_CLEAR);
        assign wr_sel[r].mset = hit && (ofs == OFS_MASK_SET);
        assign wr_sel[r].mclr = hit && (ofs == OFS_MASK_CLR);
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int NP = bank_is_playback(b) ? PLAY_PORTS : CAPT_PORTS;
        logic [NP-1:0] st;
        logic [NP-1:0] mk;

        aud_err_bank #(.PORTS(NP)) u_bank (
            .clk    (clk),
            .rst    (rst),
            .evt    (evt_i[b*PLAY_PORTS +: NP]),
            .wr     (wr_sel[b]),
            .wbits  (reg_wdata[NP-1:0]),
            .status (st),
            .mask   (mk),
            .pend   (bank_pend[b])
        );

        assign bank_status[b] = PLAY_PORTS'(st);
        assign bank_mask[b]   = PLAY_PORTS'(mk);

        if (NP < PLAY_PORTS) begin : g_narrow
            logic unused_evt;
            assign unused_evt = ^evt_i[b*PLAY_PORTS+NP +: PLAY_PORTS-NP];
        end
    end

    aud_err_summary u_summary (
        .clk        (clk),
        .rst        (rst),
        .bank_pend  (bank_pend),
        .wr         (wr_sel[SUMMARY]),
        .wbits      (reg_wdata[NUM_BANKS-1:0]),
        .top_status (top_status),
        .top_mask   (top_mask),
        .group      (group),
        .irq        (irq_o)
    );

    always_comb begin
        rd_next = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (region == REGION_W'(b)) begin
                if (ofs == OFS_STATUS) rd_next = DATA_W'(bank_status[b]);
                if (ofs == OFS_MASK)   rd_next = DATA_W'(bank_mask[b]);
            end
        end
        if (region == REGION_W'(SUMMARY)) begin
            if (ofs == OFS_STATUS) rd_next = DATA_W'(top_status);
            if (ofs == OFS_MASK)   rd_next = DATA_W'(top_mask);
            if (ofs == OFS_GROUP)  rd_next = DATA_W'(group);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rdata <= '0;
        end else if (reg_rd_en) begin
            reg_rdata <= rd_next;
        end
    end

    // R10: reads beyond the summary region return zero one edge later
    p_rd_unmapped_r10: assert property (@(posedge clk) disable iff (rst)
        (reg_rd_en && (region > REGION_W'(SUMMARY))) |=> (reg_rdata == '0));

endmodule

// File: tb/aud_err_irq_ctrl_tb_top.sv
module aud_err_irq_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [19:0] evt_i = '0;
    logic        reg_wr_en = 1'b0;
    logic        reg_rd_en = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        irq_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    aud_err_irq_ctrl dut_i (
        .clk       (clk),
        .rst       (rst),
        .evt_i     (evt_i),
        .reg_wr_en (reg_wr_en),
        .reg_rd_en (reg_rd_en),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_o     (irq_o)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // every task starts and ends just after a falling edge
    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); @(negedge clk);
        reg_wr_en = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd_chk(input logic [5:0] a, input int exp, input string req);
        reg_rd_en = 1'b1; reg_addr = a;
        @(posedge clk); @(negedge clk);
        reg_rd_en = 1'b0;
        check(req, $sformatf("read 0x%0h", a), int'(reg_rdata), exp);
    endtask

    task automatic pulse(input logic [19:0] e);
        evt_i = e;
        @(posedge clk); @(negedge clk);
        evt_i = '0;
    endtask

    task automatic pulse_wr(input logic [19:0] e, input logic [5:0] a, input logic [7:0] d);
        evt_i = e; reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); @(negedge clk);
        evt_i = '0; reg_wr_en = 1'b0; reg_wdata = '0;
    endtask

    task automatic t_reset();
        check("R1", "irq after reset", int'(irq_o), 0);
        rd_chk(6'h00, 0,    "R1");
        rd_chk(6'h02, 'h0F, "R1");
        rd_chk(6'h12, 'h07, "R8");
        rd_chk(6'h2A, 'h1F, "R1");
        rd_chk(6'h28, 0,    "R1");
    endtask

    task automatic t_masked_event();
        pulse(20'h1 << 1);              // bank 0, port 1, masked
        rd_chk(6'h00, 'h02, "R2");
        @(negedge clk); @(negedge clk);
        rd_chk(6'h28, 0, "R2");
        check("R2", "irq with masked port", int'(irq_o), 0);
        wr(6'h01, 8'h00);
        rd_chk(6'h00, 'h02, "R3");
        wr(6'h01, 8'h02);
        rd_chk(6'h00, 0, "R3");
    endtask

    task automatic t_mask_regs();
        wr(6'h1C, 8'h05);
        rd_chk(6'h1A, 'h0A, "R4");
        wr(6'h1C, 8'h00);
        rd_chk(6'h1A, 'h0A, "R4");
        wr(6'h1B, 8'h01);
        rd_chk(6'h1A, 'h0B, "R4");
    endtask

    task automatic t_summary();
        pulse(20'h1 << 14);             // bank 3, port 2, unmasked
        rd_chk(6'h28, 0,    "R5");      // summary not latched yet
        rd_chk(6'h28, 'h08, "R5");
        rd_chk(6'h18, 'h04, "R5");
        check("R7", "irq with summary masked", int'(irq_o), 0);
        wr(6'h2C, 8'h08);
        check("R7", "irq after summary unmask", int'(irq_o), 1);
        rd_chk(6'h2A, 'h17, "R7");
        rd_chk(6'h2D, 'h01, "R9");
        wr(6'h29, 8'h08);               // bank still pending
        rd_chk(6'h28, 'h08, "R6");
        wr(6'h19, 8'h04);
        wr(6'h29, 8'h08);
        rd_chk(6'h28, 0, "R6");
        check("R7", "irq after clears", int'(irq_o), 0);
    endtask

    task automatic t_capture();
        pulse(20'h1 << 19);             // bank 4, nonexistent port 3
        rd_chk(6'h20, 0, "R8");
        wr(6'h24, 8'hFF);
        rd_chk(6'h22, 0, "R8");
        pulse(20'h1 << 16);             // bank 4, port 0
        wr(6'h2C, 8'h10);
        check("R7", "irq capture unmasked", int'(irq_o), 1);
        rd_chk(6'h2D, 'h02, "R9");
        wr(6'h2B, 8'h10);
        check("R7", "irq after summary mask set", int'(irq_o), 0);
        rd_chk(6'h2D, 0, "R9");
        wr(6'h21, 8'h07);
        wr(6'h29, 8'h10);
        rd_chk(6'h28, 0, "R6");
    endtask

    task automatic t_collide();
        pulse_wr(20'h1 << 4, 6'h09, 8'h01);   // bank 1, port 0: event and clear
        rd_chk(6'h08, 'h01, "R11");
        wr(6'h09, 8'h01);
        rd_chk(6'h08, 0, "R11");
    endtask

    task automatic t_unmapped();
        rd_chk(6'h30, 0, "R10");
        rd_chk(6'h07, 0, "R10");
        wr(6'h03, 8'h00);
        rd_chk(6'h03, 0, "R10");
        rd_chk(6'h02, 'h0F, "R10");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_masked_event();
        t_mask_regs();
        t_summary();
        t_capture();
        t_collide();
        t_unmapped();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule